// File: doc/BRIEF.md
# Floppy Controller Auto-Powerdown Wake Controller

This block decides when a floppy disk controller core may sleep and which host accesses wake it. It watches the controller's host register port: a 3-bit register offset, a read strobe, a write strobe and a byte of write data. An idle timer reloads on reset and on every wake-qualifying access. When the timer has run out, the auto-powerdown enable is set and the external idle conditions hold, the block raises `pwr_down`. While the core sleeps, the drive-side output enable is low. The host decode keeps running throughout.

Whether an access wakes the core depends on its type and on the bits written. The following accesses wake the core:
- a read of the status register;
- any access to the data register;
- a drive-control write that turns a motor on;
- a software reset issued through either the drive-control register or the rate-select register.

Other writes to those two registers, and every access to the remaining offsets, are serviced without waking the core. The block keeps shadow copies of the drive-control, rate-select and configuration-control registers. Values written during powerdown are therefore kept and are in place after wake-up. A software reset also gives a one-cycle reset pulse to the core.

Top module: `apd_wake_ctrl`

## Requirements
- R1: Hardware reset (`rst_n` low) forces `pwr_down`=0, `drive_oe`=1, `soft_rst`=0, `drv_ctl_q`=8'h04, `rate_sel_q`=8'h00 and `cfg_ctl_q`=8'h00, and restarts the idle timer.
- R2: Powerdown is entered when both of these hold:
  - the clock edge comes after IDLE_CYCLES further edges with no wake access since reset or since the last wake;
  - `apd_en` and `idle_ok` are both 1 in that cycle.
  So with the conditions held throughout, `pwr_down` rises on edge IDLE_CYCLES+1. Once set, it stays set until a wake access or a reset.
- R3: While `apd_en` is 0 or `idle_ok` is 0, `pwr_down` does not rise, even after the timer has run out.
- R4: A write to offset 2 (drive control) whose bits 7:4 (motor enables) are not all zero clears `pwr_down` on the next edge. A read of offset 2 never wakes the core.
- R5: Each of these is a software reset: a write to offset 2 with bit 2 equal to 0 (active-low reset), or a write to offset 4 with bit 7 equal to 1. A software reset clears `pwr_down` on the next edge, and `soft_rst` is 1 for the cycle after that edge. A write to offset 2 or 4 that is neither a software reset nor a motor enable leaves `pwr_down` unchanged.
- R6: A read of offset 4 (main status) clears `pwr_down` on the next edge.
- R7: A read or a write of offset 5 (data) clears `pwr_down` on the next edge.
- R8: Accesses to offsets 0, 1, 3, 6 and 7 do not change `pwr_down`. Writes are stored in the shadow registers whether or not the core is asleep:
  - offset 2 → `drv_ctl_q`, stored in full;
  - offset 4 → `rate_sel_q`, with bit 7 stored as 0;
  - offset 7 → `cfg_ctl_q`, stored in full.
- R9: Any wake access reloads the idle timer to IDLE_CYCLES, including one made while the core is awake. Powerdown returns on edge IDLE_CYCLES+1 after the wake edge if the conditions hold.
- R10: `drive_oe` is the inverse of `pwr_down` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| apd_en | input | 1 | Auto-powerdown permitted |
| idle_ok | input | 1 | External idle conditions satisfied |
| bus_addr | input | 3 | Host register offset |
| bus_rd | input | 1 | Host read strobe |
| bus_wr | input | 1 | Host write strobe |
| bus_wdata | input | 8 | Host write data |
| pwr_down | output | 1 | Core is in powerdown |
| drive_oe | output | 1 | Drive-interface output enable |
| soft_rst | output | 1 | One-cycle software reset pulse to the core |
| drv_ctl_q | output | 8 | Shadow drive-control register |
| rate_sel_q | output | 8 | Shadow rate-select register (bit 7 reads 0) |
| cfg_ctl_q | output | 8 | Shadow configuration-control register |

## Verification
The bench builds the block with IDLE_CYCLES set to 8. Each wake path can therefore be followed by a full timer run and a return to powerdown within about ten cycles. This brings the exact re-entry edge after every kind of wake within reach, together with reset during powerdown and the long hold-off while the enable or the idle input is low.

// File: rtl/apd_pkg.sv
package apd_pkg;

  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 8;

  // Register offsets on the host port
  typedef enum logic [ADDR_W-1:0] {
    OFS_STAT_A   = 3'd0,
    OFS_STAT_B   = 3'd1,
    OFS_DRV_CTL  = 3'd2,
    OFS_SPARE3   = 3'd3,
    OFS_RATE_STS = 3'd4,
    OFS_DATA     = 3'd5,
    OFS_SPARE6   = 3'd6,
    OFS_CFG      = 3'd7
  } reg_ofs_e;

  localparam logic [DATA_W-1:0] DRV_CTL_RST  = 8'h04;
  localparam logic [DATA_W-1:0] RATE_SEL_RST = 8'h00;
  localparam logic [DATA_W-1:0] CFG_CTL_RST  = 8'h00;

  typedef struct packed {
    logic wake;
    logic soft_reset;
    logic wr_drv;
    logic wr_rate;
    logic wr_cfg;
  } acc_decode_t;

  // Any motor enable (bits 7:4) requested
  function automatic logic motor_request(input logic [DATA_W-1:0] d);
    return |d[7:4];
  endfunction

  // Drive-control reset bit (bit 2) is active low
  function automatic logic drv_reset_request(input logic [DATA_W-1:0] d);
    return ~d[2];
  endfunction

  // Rate-select reset bit (bit 7) is active high
  function automatic logic rate_reset_request(input logic [DATA_W-1:0] d);
    return d[7];
  endfunction

  // Rate-select reset bit is self-clearing in the shadow copy
  function automatic logic [DATA_W-1:0] rate_store_value(input logic [DATA_W-1:0] d);
    return {1'b0, d[6:0]};
  endfunction

endpackage

// File: rtl/apd_access_decode.sv
module apd_access_decode
  import apd_pkg::*;
(
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output acc_decode_t       dec
);

  always_comb begin
    dec = '0;
    case (reg_ofs_e'(bus_addr))
      OFS_DRV_CTL: begin
        dec.wr_drv     = bus_wr;
        dec.soft_reset = bus_wr & drv_reset_request(bus_wdata);
        dec.wake       = bus_wr & (motor_request(bus_wdata) | drv_reset_request(bus_wdata));
      end
      OFS_RATE_STS: begin
        dec.wr_rate    = bus_wr;
        dec.soft_reset = bus_wr & rate_reset_request(bus_wdata);
        dec.wake       = bus_rd | (bus_wr & rate_reset_request(bus_wdata));
      end
      OFS_DATA: begin
        dec.wake = bus_rd | bus_wr;
      end
      OFS_CFG: begin
        dec.wr_cfg = bus_wr;
      end
      default: dec = '0;
    endcase
  end

endmodule

// File: rtl/apd_idle_timer.sv
module apd_idle_timer #(
  parameter int unsigned IDLE_CYCLES = 240000,
  localparam int unsigned CNT_W = $clog2(IDLE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  output logic             expired,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(IDLE_CYCLES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= LOAD_VAL;
    end else if (reload) begin
      count <= LOAD_VAL;
    end else if (count != '0) begin
      count <= count - 1'b1;
    end
  end

  assign expired = (count == '0);

endmodule

// File: rtl/apd_shadow_regs.sv
module apd_shadow_regs
  import apd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  acc_decode_t       dec,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] drv_ctl_q,
  output logic [DATA_W-1:0] rate_sel_q,
  output logic [DATA_W-1:0] cfg_ctl_q
);

  localparam int unsigned NREG = 3;

  logic [NREG-1:0]             wen;
  logic [NREG-1:0][DATA_W-1:0] wval;
  logic [NREG-1:0][DATA_W-1:0] rval;
  logic [NREG-1:0][DATA_W-1:0] q;

  assign wen  = {dec.wr_cfg, dec.wr_rate, dec.wr_drv};
  assign wval = {bus_wdata, rate_store_value(bus_wdata), bus_wdata};
  assign rval = {CFG_CTL_RST, RATE_SEL_RST, DRV_CTL_RST};

  for (genvar g = 0; g < NREG; g++) begin : g_shadow
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[g] <= rval[g];
      else if (wen[g]) q[g] <= wval[g];
    end
  end

  assign drv_ctl_q  = q[0];
  assign rate_sel_q = q[1];
  assign cfg_ctl_q  = q[2];

endmodule

// File: rtl/apd_wake_ctrl.sv
module apd_wake_ctrl
  import apd_pkg::*;
#(
  // Idle interval in clock cycles (10 ms at 24 MHz by default)
  parameter int unsigned IDLE_CYCLES = 240000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apd_en,
  input  logic              idle_ok,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              pwr_down,
  output logic              drive_oe,
  output logic              soft_rst,
  output logic [DATA_W-1:0] drv_ctl_q,
  output logic [DATA_W-1:0] rate_sel_q,
  output logic [DATA_W-1:0] cfg_ctl_q
);

  localparam int unsigned CNT_W = $clog2(IDLE_CYCLES + 1);

  acc_decode_t      dec;
  logic             wake_req;
  logic             sw_reset_req;
  logic             timer_expired;
  logic             pd_enter;
  logic [CNT_W-1:0] tmr_cnt;

  apd_access_decode u_decode (
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .dec       (dec)
  );

  assign wake_req     = dec.wake;
  assign sw_reset_req = dec.soft_reset;

  apd_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .reload  (wake_req),
    .expired (timer_expired),
    .count   (tmr_cnt)
  );

  apd_shadow_regs u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec        (dec),
    .bus_wdata  (bus_wdata),
    .drv_ctl_q  (drv_ctl_q),
    .rate_sel_q (rate_sel_q),
    .cfg_ctl_q  (cfg_ctl_q)
  );

  assign pd_enter = timer_expired & apd_en & idle_ok & ~wake_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_down <= 1'b0;
      soft_rst <= 1'b0;
    end else begin
      soft_rst <= sw_reset_req;
      if (wake_req)      pwr_down <= 1'b0;
      else if (pd_enter) pwr_down <= 1'b1;
    end
  end

  assign drive_oe = ~pwr_down;

endmodule

// File: rtl/apd_wake_chk.sv
module apd_wake_chk #(
  parameter int unsigned IDLE_CYCLES = 240000,
  localparam int unsigned CNT_W = $clog2(IDLE_CYCLES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             apd_en,
  input logic             idle_ok,
  input logic [2:0]       bus_addr,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic             pwr_down,
  input logic             soft_rst,
  input logic [CNT_W-1:0] tmr_cnt
);

  // R2
  pd_entry_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_down) |-> $past(apd_en && idle_ok));

  // R9
  wake_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_down) |-> (tmr_cnt == CNT_W'(IDLE_CYCLES)));

  // R5
  srst_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (!pwr_down && $past(bus_wr)));

  // R7
  data_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && bus_addr == 3'd5) |=> !pwr_down);

  // R6
  status_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd4) |=> !pwr_down);

  // R8
  quiet_ofs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down && (bus_addr == 3'd0 || bus_addr == 3'd1 || bus_addr == 3'd3 ||
                  bus_addr == 3'd6 || bus_addr == 3'd7)) |=> pwr_down);

  // R4
  drv_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down && bus_rd && !bus_wr && bus_addr == 3'd2) |=> pwr_down);

endmodule

bind apd_wake_ctrl apd_wake_chk #(.IDLE_CYCLES(IDLE_CYCLES)) u_wake_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .apd_en   (apd_en),
  .idle_ok  (idle_ok),
  .bus_addr (bus_addr),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .pwr_down (pwr_down),
  .soft_rst (soft_rst),
  .tmr_cnt  (tmr_cnt)
);

// File: tb/apd_wake_ctrl_bench.sv
module apd_wake_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       apd_en = 1'b0;
  logic       idle_ok = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       pwr_down, drive_oe, soft_rst;
  logic [7:0] drv_ctl_q, rate_sel_q, cfg_ctl_q;

  apd_wake_ctrl #(.IDLE_CYCLES(N)) u_apd_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .apd_en(apd_en), .idle_ok(idle_ok),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .pwr_down(pwr_down), .drive_oe(drive_oe), .soft_rst(soft_rst),
    .drv_ctl_q(drv_ctl_q), .rate_sel_q(rate_sel_q), .cfg_ctl_q(cfg_ctl_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int       due;
    int       req;
    bit       pd;
    bit       srst;
    bit [7:0] drv;
    bit [7:0] rate;
    bit [7:0] cfg;
  } exp_t;

  exp_t sbq[$];
  int   n_checks = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  // Bench model state
  bit       g_apd = 0, g_ok = 0;
  bit       m_pd, m_srst;
  int       m_cnt;
  bit [7:0] m_drv, m_rate, m_cfg;

  function automatic bit b_wake(input logic [2:0] a, input bit rd, input bit wr,
                                input logic [7:0] d);
    if (a == 3'd5) return rd | wr;                                // R7
    if (a == 3'd4) return rd | (wr & d[7]);                       // R6, R5
    if (a == 3'd2) return wr & (((d & 8'hF0) != 0) || !d[2]);     // R4, R5
    return 1'b0;                                                  // R8
  endfunction

  task automatic model_reset();
    m_pd = 0; m_srst = 0; m_cnt = N;
    m_drv = 8'h04; m_rate = 8'h00; m_cfg = 8'h00;
  endtask

  task automatic model_step(input logic [2:0] a, input bit rd, input bit wr,
                            input logic [7:0] d, input int req);
    exp_t e;
    m_srst = wr && ((a == 3'd2 && !d[2]) || (a == 3'd4 && d[7]));
    if (b_wake(a, rd, wr, d)) begin
      m_pd = 0; m_cnt = N;                                        // R9
    end else begin
      if (m_cnt == 0 && g_apd && g_ok) m_pd = 1;                  // R2, R3
      if (m_cnt > 0) m_cnt = m_cnt - 1;
    end
    if (wr) begin
      if (a == 3'd2) m_drv = d;
      if (a == 3'd4) m_rate = d & 8'h7F;
      if (a == 3'd7) m_cfg = d;
    end
    e.due = cyc + 1; e.req = req; e.pd = m_pd; e.srst = m_srst;
    e.drv = m_drv; e.rate = m_rate; e.cfg = m_cfg;
    sbq.push_back(e);
  endtask

  task automatic drive(input logic [2:0] a, input bit rd, input bit wr,
                       input logic [7:0] d, input int req);
    @(negedge clk);
    bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = d;
    apd_en = g_apd; idle_ok = g_ok;
    model_step(a, rd, wr, d, req);
  endtask

  task automatic idle(input int n, input int req);
    for (int i = 0; i < n; i++) drive(3'd0, 0, 0, 8'h00, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    #1;
    rst_n = 0;
    bus_addr = '0; bus_rd = 0; bus_wr = 0; bus_wdata = '0;
    apd_en = g_apd; idle_ok = g_ok;
    repeat (3) @(negedge clk);
    #1;
    rst_n = 1;
    model_reset();
    model_step(3'd0, 0, 0, 8'h00, 1);                             // R1
  endtask

  // Monitor: pops expectations as their cycle comes up
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      exp_t e;
      e = sbq.pop_front();
      n_checks++;
      if (pwr_down !== e.pd || soft_rst !== e.srst || drv_ctl_q !== e.drv ||
          rate_sel_q !== e.rate || cfg_ctl_q !== e.cfg) begin
        n_fail++;
        $display("FAIL R%0d cyc %0d: actual pd=%b srst=%b drv=%h rate=%h cfg=%h expected pd=%b srst=%b drv=%h rate=%h cfg=%h",
                 e.req, cyc, pwr_down, soft_rst, drv_ctl_q, rate_sel_q, cfg_ctl_q,
                 e.pd, e.srst, e.drv, e.rate, e.cfg);
      end
      n_checks++;
      if (drive_oe !== !e.pd) begin
        n_fail++;
        $display("FAIL R10 cyc %0d: actual drive_oe=%b expected %b", cyc, drive_oe, !e.pd);
      end
    end
  end

  initial begin
    // R1: reset state
    g_apd = 0; g_ok = 1;
    do_reset();
    // R3: enable low holds off entry
    idle(12, 3);
    // R3: idle conditions low holds off entry
    g_apd = 1; g_ok = 0;
    idle(4, 3);
    // R2: entry once both conditions hold
    g_ok = 1;
    idle(2, 2);
    // R4: read of drive control does not wake
    drive(3'd2, 1, 0, 8'h00, 4);
    // R8: quiet offsets serviced asleep, config write stored
    drive(3'd0, 1, 0, 8'h00, 8);
    drive(3'd1, 1, 0, 8'h00, 8);
    drive(3'd7, 1, 0, 8'h00, 8);
    drive(3'd7, 0, 1, 8'h5A, 8);
    // R5: non-reset, non-motor writes leave powerdown, values stored
    drive(3'd2, 0, 1, 8'h0C, 5);
    drive(3'd4, 0, 1, 8'h03, 5);
    // R4: motor enable wakes
    drive(3'd2, 0, 1, 8'h24, 4);
    // R9: re-entry after full interval
    idle(N + 1, 9);
    // R5: drive-control software reset
    drive(3'd2, 0, 1, 8'h00, 5);
    idle(N + 1, 9);
    // R5: rate-select software reset
    drive(3'd4, 0, 1, 8'h82, 5);
    idle(N + 1, 9);
    // R6: status read wakes
    drive(3'd4, 1, 0, 8'h00, 6);
    idle(N + 1, 9);
    // R7: data read then data write wake
    drive(3'd5, 1, 0, 8'h00, 7);
    idle(N + 1, 9);
    drive(3'd5, 0, 1, 8'h33, 7);
    // R9: wake access while awake restarts the interval
    idle(4, 9);
    drive(3'd5, 1, 0, 8'h00, 9);
    idle(N + 1, 9);
    // R1: hardware reset during powerdown
    do_reset();
    idle(2, 1);
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual run still active, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule